// File: doc/BRIEF.md
# Byte-Stuffed Frame Receiver

The block accepts a stream of received bytes, one per handshake, and recovers payload frames from it. Frames are delimited by a flag byte. Payload bytes that would collide with the flag or with the escape byte arrive as two-byte escape pairs, and the block turns each pair back into the original byte. Recovered payload leaves on a valid/ready stream. Three single-cycle status pulses mark the start of a frame, the completion of a frame, and a corrupted escape pair.

Traffic may already be running when reset is released, so the block first stays silent until it sees a flag. When an escape pair is malformed, the block reports an error and drops every byte up to the next flag.

Back-pressure works as follows. The input is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low only while a payload byte is waiting in the output register and `out_ready` is low. An offered output byte keeps `out_valid` high and `out_data` unchanged until the cycle in which `out_ready` is high.

Top module: `bytestuff_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `frame_start`, `frame_done` and `frame_err` are 0 and `in_ready` is 1. The receiver starts in the hunting state.
- R2: In the hunting state after reset, every byte other than the flag 0x7E is dropped, with no payload and no pulse. A 0x7E leaves the hunting state and raises `frame_start`.
- R3: A 0x7E arriving when no payload has been seen since the last flag raises `frame_start` again and does not raise `frame_done`.
- R4: Inside a frame, a byte that is neither 0x7E nor 0x7D is output unchanged as payload.
- R5: A 0x7E arriving after at least one payload byte in the frame raises `frame_done`. That same flag may open the next frame.
- R6: The escape byte 0x7D is never output itself. A following 0x5D yields payload 0x7D, and a following 0x5E yields payload 0x7E.
- R7: After 0x7D, any byte other than 0x5D, 0x5E or 0x7E raises `frame_err`. All later bytes are dropped until a 0x7E, which raises `frame_start`.
- R8: After 0x7D, a 0x7E raises `frame_err` and `frame_start` in the same cycle, and a new frame begins.
- R9: Every payload byte and pulse appears in the cycle after the edge that accepted the byte causing it. Each pulse lasts one cycle, and `frame_done` and `frame_err` are never high together.
- R10: A payload byte not yet taken holds `out_valid` high and `out_data` stable, and holds `in_ready` low, until `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received byte offered |
| in_ready | output | 1 | Receiver can take a byte |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Payload byte offered |
| out_ready | input | 1 | Consumer takes the payload byte |
| out_data | output | 8 | Recovered payload byte |
| frame_start | output | 1 | Pulse: a flag opened a frame |
| frame_done | output | 1 | Pulse: a frame with payload was closed |
| frame_err | output | 1 | Pulse: malformed escape pair |

## Verification
Each payload byte and pulse is due one cycle after the edge that accepted its cause. The bench drives inputs at the falling edge and samples outputs at the next falling edge, which is half a cycle after that edge.

A monitor turns every output handshake and pulse into an ordered event list. A reference function computes the expected list from the accepted bytes, and the two lists are compared entry by entry. Because the comparison is by order, random gaps on both handshakes cannot shift it.

Directed probes check the one-cycle latency of a pulse and of a payload byte. They also check that a held byte stays stable while `out_ready` is low.

// File: rtl/bytestuff_rx_pkg.sv
package bytestuff_rx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_BYTE  = 8'h7E;
  localparam logic [BYTE_W-1:0] ESC_BYTE   = 8'h7D;
  localparam logic [BYTE_W-1:0] CODE_ESC   = 8'h5D;
  localparam logic [BYTE_W-1:0] CODE_FLAG  = 8'h5E;

  typedef enum logic [2:0] {
    ST_HUNT    = 3'd0,
    ST_IDLE    = 3'd1,
    ST_BODY    = 3'd2,
    ST_CLOSED  = 3'd3,
    ST_PENDING = 3'd4,
    ST_GOT_ESC = 3'd5,
    ST_GOT_FLG = 3'd6,
    ST_DROP    = 3'd7
  } rx_state_e;

  typedef struct packed {
    logic is_flag;
    logic is_esc;
    logic is_code_esc;
    logic is_code_flag;
  } byte_class_t;
endpackage

// File: rtl/bytestuff_rx_classify.sv
module bytestuff_rx_classify
  import bytestuff_rx_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic [W-1:0] byte_i,
  output byte_class_t  cls_o
);
  always_comb begin
    cls_o.is_flag      = (byte_i == W'(FLAG_BYTE));
    cls_o.is_esc       = (byte_i == W'(ESC_BYTE));
    cls_o.is_code_esc  = (byte_i == W'(CODE_ESC));
    cls_o.is_code_flag = (byte_i == W'(CODE_FLAG));
  end
endmodule

// File: rtl/bytestuff_rx_fsm.sv
module bytestuff_rx_fsm
  import bytestuff_rx_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_i,
  input  byte_class_t cls_i,
  input  logic [W-1:0] byte_i,
  output rx_state_e   state_o,
  output logic        emit_o,
  output logic [W-1:0] emit_data_o,
  output logic        start_o,
  output logic        done_o,
  output logic        err_o
);
  rx_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    emit_o      = 1'b0;
    emit_data_o = byte_i;
    start_o     = 1'b0;
    done_o      = 1'b0;
    err_o       = 1'b0;
    if (acc_i) begin
      unique case (state_q)
        ST_HUNT, ST_DROP: begin
          if (cls_i.is_flag) begin
            state_d = ST_IDLE;
            start_o = 1'b1;
          end
        end
        ST_IDLE, ST_CLOSED: begin
          if (cls_i.is_flag) begin
            state_d = ST_IDLE;
            start_o = 1'b1;
          end else if (cls_i.is_esc) begin
            state_d = ST_PENDING;
          end else begin
            state_d = ST_BODY;
            emit_o  = 1'b1;
          end
        end
        ST_BODY, ST_GOT_ESC, ST_GOT_FLG: begin
          if (cls_i.is_flag) begin
            state_d = ST_CLOSED;
            done_o  = 1'b1;
          end else if (cls_i.is_esc) begin
            state_d = ST_PENDING;
          end else begin
            state_d = ST_BODY;
            emit_o  = 1'b1;
          end
        end
        ST_PENDING: begin
          if (cls_i.is_code_esc) begin
            state_d     = ST_GOT_ESC;
            emit_o      = 1'b1;
            emit_data_o = W'(ESC_BYTE);
          end else if (cls_i.is_code_flag) begin
            state_d     = ST_GOT_FLG;
            emit_o      = 1'b1;
            emit_data_o = W'(FLAG_BYTE);
          end else if (cls_i.is_flag) begin
            state_d = ST_IDLE;
            err_o   = 1'b1;
            start_o = 1'b1;
          end else begin
            state_d = ST_DROP;
            err_o   = 1'b1;
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HUNT;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  AST_PENDING_NEEDS_ESC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_PENDING) && (state_d == ST_PENDING) |-> acc_i && cls_i.is_esc) else $error("escape state entered without escape byte"); // R6
endmodule

// File: rtl/bytestuff_rx_outreg.sv
module bytestuff_rx_outreg #(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [W-1:0] data_i,
  input  logic        ready_i,
  output logic        valid_o,
  output logic [W-1:0] data_o,
  output logic        room_o
);
  logic        vld_q;
  logic [W-1:0] dat_q;

  assign room_o = !vld_q || ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      if (load_i) begin
        vld_q <= 1'b1;
        dat_q <= data_i;
      end else if (ready_i) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign valid_o = vld_q;
  assign data_o  = dat_q;

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && !ready_i |=> vld_q && $stable(dat_q)) else $error("payload dropped or changed"); // R10
endmodule

// File: rtl/bytestuff_rx.sv
module bytestuff_rx
  import bytestuff_rx_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         frame_start,
  output logic         frame_done,
  output logic         frame_err
);
  byte_class_t  cls;
  rx_state_e    state;
  logic         acc, emit, p_start, p_done, p_err, room;
  logic [W-1:0] emit_data;
  logic         start_q, done_q, err_q;

  assign in_ready = room;
  assign acc      = in_valid && room;

  bytestuff_rx_classify #(.W(W)) u_cls (
    .byte_i (in_data),
    .cls_o  (cls)
  );

  bytestuff_rx_fsm #(.W(W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_i       (acc),
    .cls_i       (cls),
    .byte_i      (in_data),
    .state_o     (state),
    .emit_o      (emit),
    .emit_data_o (emit_data),
    .start_o     (p_start),
    .done_o      (p_done),
    .err_o       (p_err)
  );

  bytestuff_rx_outreg #(.W(W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (emit),
    .data_i  (emit_data),
    .ready_i (out_ready),
    .valid_o (out_valid),
    .data_o  (out_data),
    .room_o  (room)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      start_q <= p_start;
      done_q  <= p_done;
      err_q   <= p_err;
    end
  end

  assign frame_start = start_q;
  assign frame_done  = done_q;
  assign frame_err   = err_q;

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_err)) else $error("done and err together"); // R9
  AST_DONE_FROM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> state == ST_CLOSED) else $error("done without closed state"); // R5
  AST_ERR_IN_ESCAPE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(state) == ST_PENDING) else $error("error outside escape pair"); // R7
  AST_SILENT_WHEN_HUNTING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(state) != ST_HUNT && $past(state) != ST_DROP) else $error("payload while hunting"); // R2
endmodule

// File: tb/bytestuff_rx_tb_top.sv
module bytestuff_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, frame_start, frame_done, frame_err;
  logic [7:0] out_data;

  int vectors = 0;
  int fails = 0;
  bit rand_ready = 1'b0;
  bit fixed_ready = 1'b1;

  localparam int EV_START = 256;
  localparam int EV_ERR   = 257;
  localparam int EV_DONE  = 258;

  int exp_q[$];
  int act_q[$];

  // reference model state: 0 hunt,1 idle,2 in body,3 escape pending,4 drop
  int m_st = 0;
  bit m_payload = 0;

  always #10 clk = ~clk;

  bytestuff_rx dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .frame_start(frame_start), .frame_done(frame_done),
    .frame_err(frame_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic void model(input logic [7:0] b);
    case (m_st)
      0, 4: if (b == 8'h7E) begin m_st = 1; m_payload = 0; exp_q.push_back(EV_START); end
      1, 2: begin
        if (b == 8'h7E) begin
          if (m_payload) exp_q.push_back(EV_DONE);
          else exp_q.push_back(EV_START);
          m_st = m_payload ? 2 : 1;
          if (m_payload) begin m_payload = 0; m_st = 1; end
        end else if (b == 8'h7D) m_st = 3;
        else begin exp_q.push_back(int'(b)); m_payload = 1; m_st = 2; end
      end
      3: begin
        if (b == 8'h5D) begin exp_q.push_back(32'h7D); m_payload = 1; m_st = 2; end
        else if (b == 8'h5E) begin exp_q.push_back(32'h7E); m_payload = 1; m_st = 2; end
        else if (b == 8'h7E) begin exp_q.push_back(EV_ERR); exp_q.push_back(EV_START); m_payload = 0; m_st = 1; end
        else begin exp_q.push_back(EV_ERR); m_st = 4; end
      end
      default: m_st = 0;
    endcase
  endfunction

  // monitor: data handshake first, then pulses (err before start)
  always @(negedge clk) if (rst_n) begin
    if (out_valid && out_ready) act_q.push_back(int'(out_data));
    if (frame_done) act_q.push_back(EV_DONE);
    if (frame_err) act_q.push_back(EV_ERR);
    if (frame_start) act_q.push_back(EV_START);
  end

  always @(posedge clk) begin
    #2;
    out_ready = rand_ready ? (($urandom % 4) != 0) : fixed_ready;
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    model(b);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic gap();
    int n = $urandom % 3;
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [7:0] pick_byte();
    int r = $urandom % 10;
    case (r)
      0: return 8'h7D;
      1: return 8'h5D;
      2: return 8'h5E;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!out_valid && !frame_start && !frame_done && !frame_err, "R1 outputs idle in reset",
          {out_valid, frame_start, frame_done, frame_err}, 0);
    check(in_ready, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !frame_start && in_ready, "R1 after release", {out_valid, frame_start, in_ready}, 1);

    // R2 garbage before first flag is dropped
    send(8'h41); send(8'h7D); send(8'h13);
    @(negedge clk);
    check(act_q.size() == 0, "R2 hunting drops bytes", act_q.size(), 0);
    // R9 timing: flag pulse in the cycle after acceptance
    send(8'h7E);
    @(negedge clk);
    check(frame_start == 1'b1, "R2 R9 start pulse after flag", frame_start, 1);
    @(negedge clk);
    check(frame_start == 1'b0, "R9 pulse one cycle", frame_start, 0);
    // R4 payload latency
    send(8'h33);
    @(negedge clk);
    check(out_valid && out_data == 8'h33, "R4 R9 payload next cycle", out_data, 8'h33);

    // R10 back-pressure hold
    fixed_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    send(8'h55);
    @(negedge clk);
    check(out_valid && out_data == 8'h55 && !in_ready, "R10 held byte", {out_valid, in_ready, out_data}, {1'b1, 1'b0, 8'h55});
    repeat (3) @(negedge clk);
    check(out_valid && out_data == 8'h55 && !in_ready, "R10 still held", {out_valid, in_ready, out_data}, {1'b1, 1'b0, 8'h55});
    fixed_ready = 1'b1;

    // directed escapes and closings: R3 R5 R6 R7 R8
    send(8'h7D); send(8'h5D); send(8'h7D); send(8'h5E); send(8'h7E);
    send(8'h7E);
    send(8'h7D); send(8'h7E);
    send(8'h01); send(8'h7D); send(8'h99); send(8'h22); send(8'h7E);
    send(8'h7D); send(8'h5E); send(8'h7E);

    // random traffic
    rand_ready = 1'b1;
    for (int f = 0; f < 60; f++) begin
      int len = 1 + ($urandom % 20);
      for (int i = 0; i < len; i++) begin
        send(pick_byte());
        gap();
      end
      send(8'h7E);
      if (($urandom % 4) == 0) send(8'h7E);
    end
    rand_ready = 1'b0;
    fixed_ready = 1'b1;
    repeat (4) @(negedge clk);

    check(act_q.size() == exp_q.size(), "R4 event count", act_q.size(), exp_q.size());
    for (int k = 0; k < exp_q.size() && k < act_q.size(); k++) begin
      string tag;
      if (exp_q[k] == EV_START) tag = "R3 start";
      else if (exp_q[k] == EV_DONE) tag = "R5 done";
      else if (exp_q[k] == EV_ERR) tag = "R7 R8 err";
      else tag = "R4 R6 payload";
      check(act_q[k] == exp_q[k], tag, act_q[k], exp_q[k]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule